// File: doc/BRIEF.md
# Karatsuba Carry-Less Polynomial Multiplier

This block multiplies two polynomials whose coefficients are bits, that is, elements of GF(2). Each operand is a D-bit vector, and bit i is the coefficient of x^i. The output is the full (2D-1)-bit product. No reduction modulo a field polynomial is applied. Coefficient addition is exclusive-OR throughout, so no carries ever appear.

The product is not built as a schoolbook AND/XOR array. A recursive tree does the work, and each level has three parts:
- an evaluation step that forms operand pieces and their XOR sums;
- a point-wise step that multiplies those pieces;
- a reconstruction step that XOR-folds the sub-products back into place.

Each level splits its operands in two when the width is even, and in three otherwise. Splitting stops when each piece is a single bit, and at that point the multiply is one AND gate. The evaluation and reconstruction steps sit in a package, so that wider datapaths can reuse them.

A parameter selects an optional output register. Inputs arrive with a valid strobe. A small controller derives the capture strobe for the datapath and the output valid.

Top module: `kara_mul_top`

## Requirements
- R1: For every operand pair, `prodOut` equals the carry-less product of `aIn` and `bIn`. Bit k is the XOR over all i+j=k of `aIn[i]&bIn[j]`, over the full 2D-1 bits, with no reduction.
- R2: The default width is D=6, which makes `prodOut` 11 bits wide. D must be 1 or a product of powers of 2 and 3, and no larger than 64.
- R3: Products are linear over XOR: a·(b^c) = a·b ^ a·c.
- R4: Products commute: a·b = b·a.
- R5: With REG_OUT=1 (the default), a pair presented with `inValid`=1 at a rising edge appears on `prodOut` after that edge, and `outValid` is 1 for exactly that cycle. With REG_OUT=0, the output is combinational and `outValid` follows `inValid`.
- R6: With REG_OUT=1, a rising edge with `inValid`=0 leaves `prodOut` unchanged and drives `outValid` to 0, whatever the operand inputs carry.
- R7: While `rstN` is low, `prodOut` is 0 and `outValid` is 0, even if `inValid` is 1.
- R8: If either operand is 0, the product is 0.
- R9: If `aIn`=1 (only bit 0 set), the product equals `bIn` zero-extended to 2D-1 bits.
- R10: Bit 0 of the product is `aIn[0]&bIn[0]`, and bit 2D-2 is `aIn[D-1]&bIn[D-1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands are valid this cycle |
| aIn | input | D | First operand polynomial |
| bIn | input | D | Second operand polynomial |
| prodOut | output | 2D-1 | Carry-less product |
| outValid | output | 1 | `prodOut` holds a fresh product |

## Verification
The assertions check the following on every cycle:
- the valid latency and the hold behaviour on idle cycles;
- the zero-operand and unit-operand results;
- the two end bits of the product, which each depend on only one AND term.

Full correctness of the middle bits can only be shown by the bench. It applies all 4096 operand pairs for D=6 against a behavioural shift-and-XOR model. It also inserts idle cycles carrying junk operands. Commutativity and XOR-linearity are checked afterwards, across the recorded design outputs.

// File: rtl/kara_pkg.sv
package kara_pkg;

  localparam int MAXW = 64;
  localparam int PW   = 2 * MAXW;

  typedef logic [MAXW-1:0] opnd_t;
  typedef logic [PW-1:0]   wide_t;

  typedef struct packed {
    opnd_t p0;
    opnd_t p01;
    opnd_t p1;
  } evalTwo_t;

  typedef struct packed {
    opnd_t p0;
    opnd_t p1;
    opnd_t p2;
    opnd_t p01;
    opnd_t p12;
    opnd_t p02;
  } evalThree_t;

  typedef struct packed {
    logic capture;
    logic validNext;
  } kara_strobe_t;

  function automatic opnd_t lowMask(input int w);
    opnd_t m;
    for (int i = 0; i < MAXW; i++) m[i] = (i < w);
    return m;
  endfunction

  function automatic opnd_t piece(input opnd_t v, input int idx, input int w);
    opnd_t t;
    t = v >> (idx * w);
    return t & lowMask(w);
  endfunction

  // Evaluation for a halving step: low, sum, high.
  function automatic evalTwo_t epgTwo(input opnd_t v, input int h);
    evalTwo_t e;
    e.p0  = piece(v, 0, h);
    e.p1  = piece(v, 1, h);
    e.p01 = e.p0 ^ e.p1;
    return e;
  endfunction

  // Evaluation for a thirding step: three pieces and three pair sums.
  function automatic evalThree_t epgThree(input opnd_t v, input int t);
    evalThree_t e;
    e.p0  = piece(v, 0, t);
    e.p1  = piece(v, 1, t);
    e.p2  = piece(v, 2, t);
    e.p01 = e.p0 ^ e.p1;
    e.p12 = e.p1 ^ e.p2;
    e.p02 = e.p0 ^ e.p2;
    return e;
  endfunction

  // Reconstruction for a halving step; overlaps fold by XOR.
  function automatic wide_t recTwo(input wide_t lo, input wide_t mid,
                                   input wide_t hi, input int h);
    wide_t c1;
    c1 = lo ^ mid ^ hi;
    return lo ^ (c1 << h) ^ (hi << (2 * h));
  endfunction

  // Reconstruction for a thirding step.
  function automatic wide_t recThree(input wide_t q0, input wide_t q1,
                                     input wide_t q2, input wide_t q01,
                                     input wide_t q12, input wide_t q02,
                                     input int t);
    wide_t c1, c2, c3;
    c1 = q01 ^ q0 ^ q1;
    c2 = q02 ^ q0 ^ q1 ^ q2;
    c3 = q12 ^ q1 ^ q2;
    return q0 ^ (c1 << t) ^ (c2 << (2 * t)) ^ (c3 << (3 * t)) ^ (q2 << (4 * t));
  endfunction

endpackage

// File: rtl/kara_node.sv
module kara_node
  import kara_pkg::*;
#(
  parameter int N = 6
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-2:0] prod
);

  generate
    if (N == 1) begin : g_leaf
      assign prod = a & b;

    end else if (N % 2 == 0) begin : g_two
      localparam int H = N / 2;
      opnd_t av, bv;
      evalTwo_t ea, eb;
      logic [2*H-2:0] dLo, dMid, dHi;
      wide_t wLo, wMid, wHi, full;

      always_comb begin
        av = '0; av[N-1:0] = a;
        bv = '0; bv[N-1:0] = b;
      end
      assign ea = epgTwo(av, H);
      assign eb = epgTwo(bv, H);

      kara_node #(.N(H)) u_lo  (.a(ea.p0[H-1:0]),  .b(eb.p0[H-1:0]),  .prod(dLo));
      kara_node #(.N(H)) u_mid (.a(ea.p01[H-1:0]), .b(eb.p01[H-1:0]), .prod(dMid));
      kara_node #(.N(H)) u_hi  (.a(ea.p1[H-1:0]),  .b(eb.p1[H-1:0]),  .prod(dHi));

      always_comb begin
        wLo = '0;  wLo[2*H-2:0]  = dLo;
        wMid = '0; wMid[2*H-2:0] = dMid;
        wHi = '0;  wHi[2*H-2:0]  = dHi;
      end
      assign full = recTwo(wLo, wMid, wHi, H);
      assign prod = full[2*N-2:0];

    end else if (N % 3 == 0) begin : g_three
      localparam int T = N / 3;
      opnd_t av, bv;
      evalThree_t ea, eb;
      logic [2*T-2:0] d0, d1, d2, d01, d12, d02;
      wide_t w0, w1, w2, w01, w12, w02, full;

      always_comb begin
        av = '0; av[N-1:0] = a;
        bv = '0; bv[N-1:0] = b;
      end
      assign ea = epgThree(av, T);
      assign eb = epgThree(bv, T);

      kara_node #(.N(T)) u_0  (.a(ea.p0[T-1:0]),  .b(eb.p0[T-1:0]),  .prod(d0));
      kara_node #(.N(T)) u_1  (.a(ea.p1[T-1:0]),  .b(eb.p1[T-1:0]),  .prod(d1));
      kara_node #(.N(T)) u_2  (.a(ea.p2[T-1:0]),  .b(eb.p2[T-1:0]),  .prod(d2));
      kara_node #(.N(T)) u_01 (.a(ea.p01[T-1:0]), .b(eb.p01[T-1:0]), .prod(d01));
      kara_node #(.N(T)) u_12 (.a(ea.p12[T-1:0]), .b(eb.p12[T-1:0]), .prod(d12));
      kara_node #(.N(T)) u_02 (.a(ea.p02[T-1:0]), .b(eb.p02[T-1:0]), .prod(d02));

      always_comb begin
        w0 = '0;  w0[2*T-2:0]  = d0;
        w1 = '0;  w1[2*T-2:0]  = d1;
        w2 = '0;  w2[2*T-2:0]  = d2;
        w01 = '0; w01[2*T-2:0] = d01;
        w12 = '0; w12[2*T-2:0] = d12;
        w02 = '0; w02[2*T-2:0] = d02;
      end
      assign full = recThree(w0, w1, w2, w01, w12, w02, T);
      assign prod = full[2*N-2:0];

    end else begin : g_illegal
      // Width outside the 2^i*3^j family: output tied low.
      assign prod = '0;
    end
  endgenerate

endmodule

// File: rtl/kara_ctrl.sv
module kara_ctrl
  import kara_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output kara_strobe_t strobe,
  output logic         outValid
);

  assign strobe.capture   = inValid;
  assign strobe.validNext = inValid;

  generate
    if (REG_OUT) begin : g_reg
      logic validQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= strobe.validNext;
      end
      assign outValid = validQ;
    end else begin : g_comb
      assign outValid = rstN & strobe.validNext;
    end
  endgenerate

endmodule

// File: rtl/kara_datapath.sv
module kara_datapath
  import kara_pkg::*;
#(
  parameter int D       = 6,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rstN,
  input  kara_strobe_t   strobe,
  input  logic [D-1:0]   aIn,
  input  logic [D-1:0]   bIn,
  output logic [2*D-2:0] prodOut
);

  logic [2*D-2:0] rawProd;

  kara_node #(.N(D)) u_root (.a(aIn), .b(bIn), .prod(rawProd));

  generate
    if (REG_OUT) begin : g_reg
      logic [2*D-2:0] prodQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               prodQ <= '0;
        else if (strobe.capture) prodQ <= rawProd;
      end
      assign prodOut = prodQ;
    end else begin : g_comb
      assign prodOut = rstN ? rawProd : '0;
    end
  endgenerate

endmodule

// File: rtl/kara_mul_top.sv
module kara_mul_top
  import kara_pkg::*;
#(
  parameter int D       = 6,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic [D-1:0]   aIn,
  input  logic [D-1:0]   bIn,
  output logic [2*D-2:0] prodOut,
  output logic           outValid
);

  kara_strobe_t strobe;

  kara_ctrl #(.REG_OUT(REG_OUT)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .strobe(strobe), .outValid(outValid)
  );

  kara_datapath #(.D(D), .REG_OUT(REG_OUT)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .aIn(aIn), .bIn(bIn), .prodOut(prodOut)
  );

endmodule

// File: rtl/kara_mul_chk.sv
module kara_mul_chk #(
  parameter int D       = 6,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk,
  input logic           rstN,
  input logic           inValid,
  input logic [D-1:0]   aIn,
  input logic [D-1:0]   bIn,
  input logic [2*D-2:0] prodOut,
  input logic           outValid
);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  logic [2*D-2:0] bWide;
  assign bWide = {{(D-1){1'b0}}, bIn};

  generate
    if (REG_OUT) begin : g_reg
      p_valid_lat_r5: assert property (@(posedge clk) disable iff (!rstN)
        armed |-> (outValid == $past(inValid)));
      p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
        (armed && !$past(inValid)) |-> ($stable(prodOut) && !outValid));
      p_zero_opnd_r8: assert property (@(posedge clk) disable iff (!rstN)
        (armed && $past(inValid) && ($past(aIn) == '0 || $past(bIn) == '0))
          |-> (prodOut == '0));
      p_unit_opnd_r9: assert property (@(posedge clk) disable iff (!rstN)
        (armed && $past(inValid) && $past(aIn) == D'(1)) |-> (prodOut == $past(bWide)));
      p_end_bits_r10: assert property (@(posedge clk) disable iff (!rstN)
        (armed && $past(inValid)) |->
          (prodOut[0] == ($past(aIn[0]) & $past(bIn[0])) &&
           prodOut[2*D-2] == ($past(aIn[D-1]) & $past(bIn[D-1]))));
    end else begin : g_comb
      p_valid_lat_r5: assert property (@(posedge clk) disable iff (!rstN)
        outValid == inValid);
      p_zero_opnd_r8: assert property (@(posedge clk) disable iff (!rstN)
        (aIn == '0 || bIn == '0) |-> (prodOut == '0));
      p_unit_opnd_r9: assert property (@(posedge clk) disable iff (!rstN)
        (aIn == D'(1)) |-> (prodOut == bWide));
      p_end_bits_r10: assert property (@(posedge clk) disable iff (!rstN)
        (prodOut[0] == (aIn[0] & bIn[0])) &&
        (prodOut[2*D-2] == (aIn[D-1] & bIn[D-1])));
    end
  endgenerate

  p_reset_quiet_r7: assert property (@(posedge clk)
    !rstN |-> (!outValid && prodOut == '0));

endmodule

bind kara_mul_top kara_mul_chk #(.D(D), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .aIn(aIn), .bIn(bIn),
  .prodOut(prodOut), .outValid(outValid)
);

// File: tb/kara_mul_top_tb_top.sv
`timescale 1ns/1ps
module kara_mul_top_tb_top;

  localparam int D = 6;
  localparam int PWID = 2 * D - 1;
  localparam int NPAIR = 1 << (2 * D);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [D-1:0] aIn = '0;
  logic [D-1:0] bIn = '0;
  logic [PWID-1:0] prodOut;
  logic outValid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int cycles = 0;

  logic [PWID-1:0] dutRes [0:NPAIR-1];

  always #10 clk = ~clk;

  kara_mul_top dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .aIn(aIn), .bIn(bIn),
    .prodOut(prodOut), .outValid(outValid)
  );

  function automatic logic [PWID-1:0] clmul(input logic [D-1:0] a, input logic [D-1:0] b);
    logic [PWID-1:0] acc;
    acc = '0;
    for (int i = 0; i < D; i++)
      if (a[i]) acc = acc ^ (PWID'(b) << i);
    return acc;
  endfunction

  task automatic check(input string req, input logic [PWID-1:0] act,
                       input logic [PWID-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference model state: what the output should show after the last edge.
  logic [PWID-1:0] expProd = '0;
  logic            expValid = 1'b0;
  int              expTag = 0;
  logic [D-1:0]    expA = '0;
  logic [D-1:0]    expB = '0;

  task automatic compareNow();
    string req;
    check("R5 valid", PWID'(outValid), PWID'(expValid));
    if (expValid) begin
      if (expA == 0 || expB == 0) req = "R8 zero";
      else if (expA == 1)         req = "R9 unit";
      else                        req = "R1 product";
      check(req, prodOut, expProd);
      check("R10 end bits", {prodOut[PWID-1], prodOut[0]},
            {expProd[PWID-1], expProd[0]});
      dutRes[expTag] = prodOut;
    end else begin
      check("R6 hold", prodOut, expProd);
    end
  endtask

  // Called at a falling edge: present inputs and advance the model.
  task automatic present(input logic v, input logic [D-1:0] a, input logic [D-1:0] b);
    inValid = v; aIn = a; bIn = b;
    expValid = v;
    if (v) begin
      expProd = clmul(a, b);
      expTag = int'({a, b});
      expA = a; expB = b;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int seq;
    check("R2 width", PWID'($bits(prodOut)), PWID'(11));
    // Reset with live inputs: outputs must stay quiet (R7).
    inValid = 1'b1; aIn = 6'h3F; bIn = 6'h2D;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7 reset prod", prodOut, '0);
    check("R7 reset valid", PWID'(outValid), '0);
    inValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    expProd = '0; expValid = 1'b0;
    @(negedge clk);
    compareNow();

    // Exhaustive sweep with idle cycles carrying junk operands (R6).
    seq = 0;
    for (int a = 0; a < (1 << D); a++) begin
      for (int b = 0; b < (1 << D); b++) begin
        present(1'b1, D'(a), D'(b));
        @(negedge clk);
        compareNow();
        seq++;
        if (seq % 7 == 0) begin
          present(1'b0, D'(b * 5 + 3), D'(a ^ 6'h2A));
          @(negedge clk);
          compareNow();
          present(1'b0, ~D'(a), ~D'(b));
          @(negedge clk);
          compareNow();
        end
      end
    end
    present(1'b0, '0, '0);
    @(negedge clk);
    compareNow();

    // Algebraic properties over recorded design outputs.
    for (int a = 0; a < (1 << D); a++) begin
      for (int b = 0; b < (1 << D); b++) begin
        int c;
        c = (b + 5) % (1 << D);
        check("R4 commute", dutRes[a * (1 << D) + b], dutRes[b * (1 << D) + a]);
        check("R3 xor-linear", dutRes[a * (1 << D) + (b ^ c)],
              dutRes[a * (1 << D) + b] ^ dutRes[a * (1 << D) + c]);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule